// File: doc/BRIEF.md
# Handler Entry Sequencer for a 16-bit Stack Processor

This block decides which event sends a 16-bit stack processor into a handler, and then carries out the memory traffic for that entry. The events are a power-on reset, four prioritized hardware interrupt lines and two kinds of trap: an illegal-operation trap and a software trap. The block pushes the required state onto the downward-growing call stack. It reads the handler address, and the handler data-stack pointer when one is needed, from a vector table at the top of memory. It then hands the new instruction pointer, data-stack pointer and call-stack pointer back to the execution core.

The block also holds the processor's status word. Bits 15:12 are the interrupt mask, with level 4 at bit 15 and level 1 at bit 12. Bit 11 enables I/O and bit 10 marks privileged mode. Bits 9:1 are reserved and bit 0 is the carry. The core can ask the block to restore this word. When privileged mode is off, a restore can change only the carry.

An event is accepted only while the block is idle and the core marks an instruction boundary. Every memory step holds its request until an acknowledge arrives. The block counts as being in interrupt mode whenever any mask bit is set.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is active the status word is 0x0400. After reset is released, the first memory access is a read at 0xFFF6 and no call-stack write happens. The reset entry completes with `ip_out` equal to the word read.
- R2: A new entry starts only when the block is idle and `boundary` is high. When several events are pending, the highest-numbered unmasked interrupt wins. Any unmasked interrupt beats both traps, and the illegal-operation trap beats the software trap. `busy` is high from the cycle after the start until the entry completes.
- R3: Interrupt level n (for n from 1 to 4, on `irq_req[n-1]`) is ignored while status bit 11+n is set. With no other event pending, nothing starts and no memory request is made.
- R4: Each call-stack write first lowers the pointer by 2 and then writes at the new address. The writes come in the order instruction pointer, data-stack pointer, status word. Address, direction and data stay unchanged until `mem_ack` is seen.
- R5: When an interrupt is taken while all mask bits are clear, the entry also saves `dsp_in` and reads a new data-stack pointer from 0xFFF0, and it completes with `dsp_load` high. In every other case the entry neither saves nor reloads the data-stack pointer, and `dsp_load` is low.
- R6: The handler address is read last. It comes from 0xFFF6+2n for interrupt level n, from 0xFFF4 for the illegal-operation trap and from 0xFFF2 for the software trap.
- R7: An illegal-operation trap saves the instruction pointer and then the status word. A software trap saves only the status word.
- R8: Completing an interrupt entry at level n sets mask bits for levels 1 through n, and also sets bits 11 and 10. Completing a trap entry sets bits 11 and 10 only. The carry and all other bits are kept in both cases.
- R9: A restore while bit 10 is set loads all 16 bits of `msk_restore_data`. A restore while bit 10 is clear changes only bit 0.
- R10: While `busy` is high, a restore request has no effect, and the status word changes only when the final read is acknowledged.
- R11: `done` is a one-cycle pulse in the cycle after the final read is acknowledged. In that cycle `ip_out` holds the word read and `csp_out` holds the lowered call-stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the reset entry |
| boundary | input | 1 | Core is at an instruction boundary |
| irq_req | input | 4 | Interrupt requests, bit 0 is level 1 |
| trap_ill | input | 1 | Illegal-operation trap request |
| trap_sw | input | 1 | Software trap request |
| ip_in | input | 16 | Current instruction pointer |
| dsp_in | input | 16 | Current data-stack pointer |
| csp_in | input | 16 | Current call-stack pointer |
| msk_restore | input | 1 | Restore the status word |
| msk_restore_data | input | 16 | Value to restore |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Entry complete, new values valid |
| ip_out | output | 16 | New instruction pointer |
| dsp_load | output | 1 | Data-stack pointer is to be reloaded |
| dsp_out | output | 16 | New data-stack pointer |
| csp_out | output | 16 | New call-stack pointer |
| status | output | 16 | Status word |

## Verification
The bench builds the block with its default values: a 16-bit word and four interrupt levels. With these values every vector table slot is reachable, and both the all-clear and the fully-set state of the mask field can be driven. The bench varies the acknowledge latency from zero to two wait cycles, so both the held-request path and the same-cycle acknowledge path are exercised. It also walks the privileged/unprivileged restore paths, a restore attempt in the middle of an entry, and simultaneous requests that test every priority order.

// File: rtl/tes_pkg.sv
// Shared types for the handler entry sequencer.
// Assumes the vector table layout is fixed relative to its base; offsets below are in bytes.
package tes_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_WR_IP, ST_WR_DSP, ST_WR_MSK, ST_RD_DSP, ST_RD_IP
    } seq_st_e;

    typedef enum logic [1:0] {EV_RESET, EV_IRQ, EV_ILL, EV_SWI} ev_e;

    // Byte offset of a vector slot above the table base.
    function automatic int vec_off(ev_e ev, int lvl);
        case (ev)
            EV_IRQ:   return 8 + 2 * lvl;
            EV_RESET: return 6;
            EV_ILL:   return 4;
            default:  return 2;
        endcase
    endfunction
endpackage

// File: rtl/tes_arb.sv
// Event arbiter: picks the winning pending event.
// Assumes mask[i]=1 blocks level i+1; the highest unmasked level wins, then illegal trap, then software trap.
module tes_arb #(
    parameter int NIRQ = 4,
    parameter int LW   = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] mask,
    input  logic            trap_ill,
    input  logic            trap_sw,
    output logic            ev_valid,
    output tes_pkg::ev_e    ev,
    output logic [LW-1:0]   lvl
);
    import tes_pkg::*;

    logic hit;

    // Priority scan: later (higher) levels overwrite earlier ones.
    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (irq_req[i] && !mask[i]) begin
                hit = 1'b1;
                lvl = LW'(i);
            end
        end
        ev_valid = hit | trap_ill | trap_sw;
        ev = hit ? EV_IRQ : (trap_ill ? EV_ILL : EV_SWI);
    end
endmodule

// File: rtl/tes_status.sv
// Status word register with entry update and guarded restore.
// Assumes apply and restore never both matter in one cycle (restore_ok is low while an entry runs).
module tes_status #(
    parameter int DW   = 16,
    parameter int NIRQ = 4,
    parameter int LW   = $clog2(NIRQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restore_en,
    input  logic          restore_ok,
    input  logic [DW-1:0] restore_data,
    input  logic          apply,
    input  tes_pkg::ev_e  apply_ev,
    input  logic [LW-1:0] apply_lvl,
    output logic [DW-1:0] status
);
    import tes_pkg::*;

    localparam int MLO = DW - NIRQ;
    localparam int BIB = MLO - 1;
    localparam int BSB = MLO - 2;

    logic [NIRQ-1:0] lvl_bits;
    logic [DW-1:0]   entry_val;

    // Value the word takes when an entry completes.
    always_comb begin
        lvl_bits = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (i <= int'(apply_lvl)) lvl_bits[i] = 1'b1;
        end
        entry_val = status;
        entry_val[BSB] = 1'b1;
        entry_val[BIB] = 1'b1;
        if (apply_ev == EV_IRQ) entry_val[DW-1:MLO] = status[DW-1:MLO] | lvl_bits;
    end

    // Register update: reset, entry, then restore (full or carry-only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status      <= '0;
            status[BSB] <= 1'b1;
        end else if (apply) begin
            status <= entry_val;
        end else if (restore_en && restore_ok) begin
            if (status[BSB]) status    <= restore_data;
            else             status[0] <= restore_data[0];
        end
    end
endmodule

// File: rtl/tes_fsm.sv
// Entry sequencer: saves state on the call stack and reads vectors.
// Assumes memory holds address/data stable transfers on req&ack; pointer is pre-decremented by 2.
module tes_fsm #(
    parameter int DW   = 16,
    parameter int NIRQ = 4,
    parameter int LW   = $clog2(NIRQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          ev_valid,
    input  tes_pkg::ev_e  ev,
    input  logic [LW-1:0] lvl,
    input  logic          mask_any,
    input  logic [DW-1:0] ip_in,
    input  logic [DW-1:0] dsp_in,
    input  logic [DW-1:0] csp_in,
    input  logic [DW-1:0] status,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          apply,
    output tes_pkg::ev_e  apply_ev,
    output logic [LW-1:0] apply_lvl,
    output logic          done,
    output logic [DW-1:0] ip_out,
    output logic [DW-1:0] dsp_out,
    output logic          dsp_load,
    output logic [DW-1:0] csp_out
);
    import tes_pkg::*;

    localparam logic [DW-1:0] VBASE = ~DW'(2 * (4 + NIRQ) - 1);

    seq_st_e       st;
    ev_e           ev_r;
    logic [LW-1:0] lvl_r;
    logic          to_int;
    logic [DW-1:0] ip_sv, dsp_sv, csp_r;
    logic          is_wr;
    logic          start;

    assign start     = (st == ST_IDLE) && boundary && ev_valid;
    assign is_wr     = (st == ST_WR_IP) || (st == ST_WR_DSP) || (st == ST_WR_MSK);
    assign busy      = (st != ST_IDLE);
    assign apply     = (st == ST_RD_IP) && mem_ack && (ev_r != EV_RESET);
    assign apply_ev  = ev_r;
    assign apply_lvl = lvl_r;
    assign csp_out   = csp_r;

    // Memory request outputs decoded from the current step.
    always_comb begin
        mem_req   = is_wr || (st == ST_RD_DSP) || (st == ST_RD_IP);
        mem_we    = is_wr;
        mem_addr  = is_wr ? csp_r - DW'(2) : VBASE;
        if (st == ST_RD_IP) mem_addr = VBASE + DW'(vec_off(ev_r, int'(lvl_r)));
        case (st)
            ST_WR_IP:  mem_wdata = ip_sv;
            ST_WR_DSP: mem_wdata = dsp_sv;
            ST_WR_MSK: mem_wdata = status;
            default:   mem_wdata = '0;
        endcase
    end

    // Step sequencing, pointer tracking and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_RD_IP;
            ev_r     <= EV_RESET;
            lvl_r    <= '0;
            to_int   <= 1'b0;
            ip_sv    <= '0;
            dsp_sv   <= '0;
            csp_r    <= '0;
            done     <= 1'b0;
            ip_out   <= '0;
            dsp_out  <= '0;
            dsp_load <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                ev_r   <= ev;
                lvl_r  <= lvl;
                to_int <= (ev == EV_IRQ) && !mask_any;
                ip_sv  <= ip_in;
                dsp_sv <= dsp_in;
                csp_r  <= csp_in;
                st     <= (ev == EV_SWI) ? ST_WR_MSK : ST_WR_IP;
            end else if (mem_req && mem_ack) begin
                if (is_wr) csp_r <= csp_r - DW'(2);
                case (st)
                    ST_WR_IP:  st <= to_int ? ST_WR_DSP : ST_WR_MSK;
                    ST_WR_DSP: st <= ST_WR_MSK;
                    ST_WR_MSK: st <= to_int ? ST_RD_DSP : ST_RD_IP;
                    ST_RD_DSP: begin
                        dsp_out <= mem_rdata;
                        st      <= ST_RD_IP;
                    end
                    ST_RD_IP: begin
                        ip_out   <= mem_rdata;
                        dsp_load <= to_int;
                        done     <= 1'b1;
                        st       <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Top of the handler entry sequencer: arbiter, status word and step sequencer.
// Assumes the core holds inputs steady while boundary is high and applies outputs on done.
module trap_entry_seq #(
    parameter int DW   = 16,
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary,
    input  logic [NIRQ-1:0] irq_req,
    input  logic            trap_ill,
    input  logic            trap_sw,
    input  logic [DW-1:0]   ip_in,
    input  logic [DW-1:0]   dsp_in,
    input  logic [DW-1:0]   csp_in,
    input  logic            msk_restore,
    input  logic [DW-1:0]   msk_restore_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   ip_out,
    output logic            dsp_load,
    output logic [DW-1:0]   dsp_out,
    output logic [DW-1:0]   csp_out,
    output logic [DW-1:0]   status
);
    import tes_pkg::*;

    localparam int LW  = $clog2(NIRQ);
    localparam int MLO = DW - NIRQ;

    logic          ev_valid, apply;
    ev_e           ev, apply_ev;
    logic [LW-1:0] lvl, apply_lvl;

    tes_arb #(.NIRQ(NIRQ), .LW(LW)) u_arb (
        .irq_req(irq_req), .mask(status[DW-1:MLO]), .trap_ill(trap_ill),
        .trap_sw(trap_sw), .ev_valid(ev_valid), .ev(ev), .lvl(lvl)
    );

    tes_status #(.DW(DW), .NIRQ(NIRQ), .LW(LW)) u_status (
        .clk(clk), .rst_n(rst_n), .restore_en(msk_restore), .restore_ok(!busy),
        .restore_data(msk_restore_data), .apply(apply), .apply_ev(apply_ev),
        .apply_lvl(apply_lvl), .status(status)
    );

    tes_fsm #(.DW(DW), .NIRQ(NIRQ), .LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .ev_valid(ev_valid),
        .ev(ev), .lvl(lvl), .mask_any(|status[DW-1:MLO]), .ip_in(ip_in),
        .dsp_in(dsp_in), .csp_in(csp_in), .status(status), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .apply(apply),
        .apply_ev(apply_ev), .apply_lvl(apply_lvl), .done(done), .ip_out(ip_out),
        .dsp_out(dsp_out), .dsp_load(dsp_load), .csp_out(csp_out)
    );
endmodule

// File: rtl/trap_entry_seq_chk.sv
// Protocol and status-word checks for trap_entry_seq, attached by bind.
// Assumes the default layout: mask in the top NIRQ bits, privileged bit two below them.
module trap_entry_seq_chk #(
    parameter int DW   = 16,
    parameter int NIRQ = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          msk_restore,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          busy,
    input logic          done,
    input logic          dsp_load,
    input logic [DW-1:0] status
);
    localparam int MLO = DW - NIRQ;
    localparam int BSB = MLO - 2;

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r11_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_ack && !mem_we));

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_priv_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status[BSB]);

    a_r5_int_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dsp_load) |-> (status[DW-1:MLO] != '0));

    a_r9_user_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_restore && !busy && !status[BSB]) |=> (status[DW-1:1] == $past(status[DW-1:1])));

    a_r10_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> $stable(status));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.DW(DW), .NIRQ(NIRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .msk_restore(msk_restore), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .busy(busy),
    .done(done), .dsp_load(dsp_load), .status(status)
);

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
// Bench: behavioural reference (expected memory log queue, expected status word) checked every clock.
module sim_trap_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic [3:0]  irq_req = '0;
    logic        trap_ill = 1'b0, trap_sw = 1'b0;
    logic [15:0] ip_in = '0, dsp_in = '0, csp_in = '0;
    logic        msk_restore = 1'b0;
    logic [15:0] msk_restore_data = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, dsp_load;
    logic [15:0] ip_out, dsp_out, csp_out, status;

    int checks = 0, errors = 0, cyc = 0;
    int lat = 0, cnt = 0;
    bit mon_on = 1'b0;
    logic [15:0] exp_msk = 16'h0400;
    logic [32:0] log_q[$];
    logic [32:0] exp_q[$];

    always #2 clk = ~clk;

    function automatic logic [15:0] vecval(logic [15:0] a);
        return a ^ 16'h3C3C;
    endfunction

    assign mem_rdata = vecval(mem_addr);

    trap_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq_req(irq_req),
        .trap_ill(trap_ill), .trap_sw(trap_sw), .ip_in(ip_in), .dsp_in(dsp_in),
        .csp_in(csp_in), .msk_restore(msk_restore), .msk_restore_data(msk_restore_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .ip_out(ip_out), .dsp_load(dsp_load), .dsp_out(dsp_out), .csp_out(csp_out),
        .status(status)
    );

    task automatic chk(bit ok, string req, string what, logic [32:0] act, logic [32:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    // Per-clock comparison of the status word against the model (R8, R9, R10).
    always @(posedge clk) begin
        if (mon_on) chk(status === exp_msk, "R8 R9 R10", "status per clock", {17'b0, status}, {17'b0, exp_msk});
    end

    // Memory responder with programmable wait cycles; logs every transfer.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            cnt = lat;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            cnt = lat;
        end else if (mem_req) begin
            if (cnt == 0) begin
                mem_ack = 1'b1;
                log_q.push_back({mem_we, mem_addr, mem_we ? mem_wdata : vecval(mem_addr)});
            end else begin
                cnt--;
            end
        end
    end

    task automatic wait_done(string req);
        int n = 0;
        while (done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, req, "done seen", {32'b0, done}, 33'd1);
    endtask

    task automatic cmp_log(string req);
        chk(log_q.size() == exp_q.size(), req, "memory step count", 33'(log_q.size()), 33'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            chk(log_q[i] === exp_q[i], req, "memory step", log_q[i], exp_q[i]);
    endtask

    // kind: 0 interrupt, 1 illegal trap, 2 software trap
    task automatic entry(int kind, int lvl, logic [3:0] irqs, bit ill, bit sw,
                         logic [15:0] csp, int latency, bit restore_mid);
        bit          to_int;
        logic [15:0] c, ipv, dspv, va;
        ipv    = 16'h2460 + 16'(kind * 16 + lvl);
        dspv   = 16'h7E00 - 16'(lvl * 8);
        to_int = (kind == 0) && (exp_msk[15:12] == 4'h0);
        c      = csp;
        va     = (kind == 0) ? 16'hFFF8 + 16'(2 * lvl) : (kind == 1 ? 16'hFFF4 : 16'hFFF2);
        exp_q.delete();
        log_q.delete();
        if (kind != 2) begin c = c - 2; exp_q.push_back({1'b1, c, ipv}); end
        if (to_int)    begin c = c - 2; exp_q.push_back({1'b1, c, dspv}); end
        c = c - 2;
        exp_q.push_back({1'b1, c, exp_msk});
        if (to_int) exp_q.push_back({1'b0, 16'hFFF0, vecval(16'hFFF0)});
        exp_q.push_back({1'b0, va, vecval(va)});
        lat = latency;
        cnt = latency;
        ip_in = ipv; dsp_in = dspv; csp_in = csp;
        irq_req = irqs; trap_ill = ill; trap_sw = sw; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0; irq_req = '0; trap_ill = 1'b0; trap_sw = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", {32'b0, busy}, 33'd1);
        if (restore_mid) begin
            msk_restore = 1'b1;
            msk_restore_data = 16'h0000;
            @(negedge clk);
            msk_restore = 1'b0;
        end
        wait_done("R11");
        exp_msk[10] = 1'b1;
        exp_msk[11] = 1'b1;
        if (kind == 0)
            for (int i = 0; i <= lvl; i++) exp_msk[12 + i] = 1'b1;
        cmp_log(kind == 2 ? "R7 R4 R6" : "R2 R4 R5 R6 R7");
        chk(ip_out === vecval(va), "R6", "ip_out", {17'b0, ip_out}, {17'b0, vecval(va)});
        chk(dsp_load === to_int, "R5", "dsp_load", {32'b0, dsp_load}, {32'b0, to_int});
        if (to_int) chk(dsp_out === vecval(16'hFFF0), "R5", "dsp_out", {17'b0, dsp_out}, {17'b0, vecval(16'hFFF0)});
        chk(csp_out === c, "R11", "csp_out", {17'b0, csp_out}, {17'b0, c});
        @(negedge clk);
        chk(done === 1'b0, "R11", "done is one cycle", {32'b0, done}, 33'd0);
        chk(status === exp_msk, "R8", "status after entry", {17'b0, status}, {17'b0, exp_msk});
    endtask

    task automatic restore(logic [15:0] data, logic [15:0] expect_new);
        msk_restore = 1'b1;
        msk_restore_data = data;
        @(negedge clk);
        msk_restore = 1'b0;
        exp_msk = expect_new;
        @(negedge clk);
        chk(status === exp_msk, "R9", "status after restore", {17'b0, status}, {17'b0, exp_msk});
    endtask

    task automatic no_start(logic [3:0] irqs, bit bnd, string req);
        log_q.delete();
        irq_req = irqs;
        boundary = bnd;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(busy === 1'b0 && mem_req === 1'b0, req, "no entry started", {31'b0, busy, mem_req}, 33'd0);
        end
        irq_req = '0;
        boundary = 1'b0;
        chk(log_q.size() == 0, req, "no memory traffic", 33'(log_q.size()), 33'd0);
    endtask

    initial begin
        lat = 1;
        cnt = 1;
        repeat (3) @(negedge clk);
        chk(status === 16'h0400, "R1", "status in reset", {17'b0, status}, 33'h0400);
        rst_n = 1'b1;
        exp_msk = 16'h0400;
        mon_on = 1'b1;
        exp_q.delete();
        exp_q.push_back({1'b0, 16'hFFF6, vecval(16'hFFF6)});
        wait_done("R1");
        cmp_log("R1");
        chk(ip_out === vecval(16'hFFF6), "R1", "reset ip_out", {17'b0, ip_out}, {17'b0, vecval(16'hFFF6)});
        @(negedge clk);

        // R9: privileged restore writes everything, user restore only the carry.
        restore(16'h0000, 16'h0000);
        restore(16'hFC01, 16'h0001);
        restore(16'h0C00, 16'h0000);
        restore(16'hFFFF, 16'h0001);

        // R2 R5: level 2 from user mode beats both traps.
        entry(0, 1, 4'b0010, 1'b1, 1'b1, 16'h4000, 0, 1'b0);
        // R2 R3: levels 1 and 2 masked, level 4 wins, no data-stack switch.
        entry(0, 3, 4'b1011, 1'b0, 1'b0, 16'h3FF4, 2, 1'b0);
        // R3: everything masked.
        no_start(4'b1111, 1'b1, "R3");

        restore(16'h0400, 16'h0400);
        // R2: boundary low keeps the block idle.
        no_start(4'b0001, 1'b0, "R2");
        // R2 R7: illegal trap beats software trap.
        entry(1, 0, 4'b0000, 1'b1, 1'b1, 16'h5000, 1, 1'b0);
        // R7 R10: software trap with a restore attempt mid-entry.
        entry(2, 0, 4'b0000, 1'b0, 1'b1, 16'h4FFC, 0, 1'b1);
        // R5 R6: level 3 taken from non-interrupt mode.
        entry(0, 2, 4'b0100, 1'b0, 1'b0, 16'h6000, 1, 1'b0);
        // R3: levels 1..3 now masked.
        no_start(4'b0111, 1'b1, "R3");

        finish_run();
    end
endmodule